// File: doc/BRIEF.md
# Serial Link Frame Transmitter

This block turns 36-bit words from an application buffer into a continuous serial stream of fixed-size frames, one serial bit per core clock. Every frame carries the payload plus four overhead bits: a two-bit header that tells data, flagged data and idle apart, a bus-invert bit for DC balance, and an even parity bit. When the application offers no word, or the clock source is not locked, idle stuffing frames keep the line busy so that a receiver can hold alignment.

Words are pulled with a read strobe. The strobe pulses for one cycle at the last bit slot of a frame, but only while the application holds its valid input high and lock is present. The word on the data pins is captured at the clock edge that ends that cycle. Holding valid high gives back-to-back bursts. Dropping valid after one pulse sends exactly one word. Parity is either generated inside the block or checked against a bit that the application supplies. A rising edge on the sideband flag input marks the next data frame and stretches it by one idle bit slot.

Top module: `link_frame_tx`

## Requirements
- R1: A frame is 40 bits, sent MSB first, laid out as {header[1:0], invert, parity, payload[35:0]}. Header 2'b10 marks a data frame, 2'b11 a data frame carrying the flag, and 2'b01 a stuffing frame.
- R2: The parity bit is the even parity (XOR) of the captured 36-bit word. It is transmitted whatever the value of par_i.
- R3: A running disparity starts at 0 and adds (2·ones − 36) of each transmitted payload. A data word is inverted, with the invert bit set to 1, exactly when the running disparity and the word's own disparity are both positive or both negative.
- R4: rd_strobe_o is a one-cycle pulse. It is raised only in the last bit slot of a frame, and only while valid_i and lock_i are high. The word is captured at the edge that ends that cycle. With valid_i held high, successive pulses are one frame length apart.
- R5: A frame slot with no captured word sends a stuffing frame: header 01, invert 0, parity 0, payload 36'hAAAAAAAAA.
- R6: If valid_i falls after one strobe pulse, exactly one data frame is sent and the following frame is stuffing.
- R7: par_err_n_o is updated at every frame load. It goes low only when a word is captured with par_gen_i = 0 and par_i differs from the computed parity. With par_gen_i = 1 it stays high.
- R8: A rising edge on flag_i sets a pending flag. The next data frame carries header 11 and is followed by one extra bit slot of value 0 (41 cycles). The pending flag is then cleared.
- R9: rst_n is asynchronous and active low. It forces par_err_n_o to 1 and clears the running disparity. After release, a stuffing frame goes out starting with its MSB.
- R10: While lock_i is low no strobe is issued and only stuffing frames are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Clock source locked; block is ready |
| valid_i | input | 1 | Application has a word available |
| data_i | input | 36 | Word to transmit |
| par_i | input | 1 | Application-supplied parity bit |
| par_gen_i | input | 1 | 1: generate parity internally, 0: check par_i |
| flag_i | input | 1 | Sideband flag; rising edge marks the next data frame |
| rd_strobe_o | output | 1 | Read strobe to the application buffer |
| par_err_n_o | output | 1 | Active-low parity mismatch indication |
| ser_o | output | 1 | Serial frame stream |

## Verification
Several properties are checked on every cycle: the running disparity stays within ±36, inverting a word always lowers a positive disparity, and a consumed flag clears its pending state. The checks also confirm that a strobe is always followed by a data header bit, that an unlocked load always starts a stuffing frame, and that generate mode never flags an error. The bench scenarios are what show the exact frame contents: the bus-invert decisions across a sequence of words, the 41-slot flagged frame with its trailing zero, burst spacing against single-word fallback to stuffing, and the asynchronous reset of the error output.

// File: rtl/lft_pkg.sv
package lft_pkg;
  typedef enum logic [1:0] {
    HDR_STUFF = 2'b01,
    HDR_DATA  = 2'b10,
    HDR_FLAG  = 2'b11
  } hdr_e;

  localparam int OVH_W = 4;
endpackage

// File: rtl/lft_flag_latch.sv
module lft_flag_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_in,
  input  logic take,
  output logic flag_now
);
  logic flag_q;
  logic pending;
  logic rise;

  assign rise     = flag_in & ~flag_q;
  assign flag_now = pending | rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pending <= 1'b0;
    end else begin
      flag_q <= flag_in;
      if (take)      pending <= 1'b0;
      else if (rise) pending <= 1'b1;
    end
  end

  // R8: a flag handed to a data frame is not reused
  assert_flag_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && flag_now) |=> !pending);
endmodule

// File: rtl/lft_encoder.sv
module lft_encoder import lft_pkg::*; #(
  parameter int DATA_W = 36
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      use_data,
  input  logic                      flag,
  input  logic [DATA_W-1:0]         data,
  output logic [DATA_W+OVH_W-1:0]   frame,
  output logic [DATA_W+OVH_W-1:0]   idle_frame,
  output logic                      calc_par
);
  localparam int DISP_W = $clog2(DATA_W + 1) + 2;

  function automatic logic [DATA_W-1:0] stuff_word();
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W; i++) w[i] = i[0];
    return w;
  endfunction

  function automatic logic signed [DISP_W-1:0] word_disp(input logic [DATA_W-1:0] d);
    int ones;
    ones = 0;
    for (int i = 0; i < DATA_W; i++) ones += int'(d[i]);
    return DISP_W'(2 * ones - DATA_W);
  endfunction

  localparam logic [DATA_W-1:0] STUFF = stuff_word();

  logic signed [DISP_W-1:0] run_disp;
  logic signed [DISP_W-1:0] in_disp;
  logic signed [DISP_W-1:0] out_disp;
  logic                     invert;
  logic [DATA_W-1:0]        payload;
  hdr_e                     hdr;

  always_comb begin
    in_disp  = word_disp(data);
    invert   = use_data && (((run_disp > 0) && (in_disp > 0)) ||
                            ((run_disp < 0) && (in_disp < 0)));
    payload  = use_data ? (invert ? ~data : data) : STUFF;
    calc_par = ^data;
    hdr      = !use_data ? HDR_STUFF : (flag ? HDR_FLAG : HDR_DATA);
    frame    = {hdr, invert, (use_data ? calc_par : ^STUFF), payload};
    out_disp = word_disp(payload);
  end

  assign idle_frame = {HDR_STUFF, 1'b0, ^STUFF, STUFF};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_disp <= '0;
    else if (load) run_disp <= run_disp + out_disp;
  end

  // R3: bus-invert keeps the running disparity bounded by one word
  assert_disp_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(run_disp) <= DATA_W) && (int'(run_disp) >= -DATA_W));

  // R3: a positive disparity met by a positive word must fall
  assert_invert_lowers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && use_data && (run_disp > 0) && (in_disp > 0)) |=> (run_disp < $past(run_disp)));
endmodule

// File: rtl/lft_shifter.sv
module lft_shifter #(
  parameter int FRAME_W = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stretch,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [FRAME_W-1:0] idle_frame,
  output logic               load_now,
  output logic               ser_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_idx;
  logic [CNT_W-1:0]   last_idx;

  assign load_now = (bit_idx == last_idx);
  assign ser_o    = shreg[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= idle_frame;
      bit_idx  <= '0;
      last_idx <= CNT_W'(FRAME_W - 1);
    end else if (load_now) begin
      shreg    <= frame_in;
      bit_idx  <= '0;
      last_idx <= stretch ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
    end else begin
      shreg   <= {shreg[FRAME_W-2:0], 1'b0};
      bit_idx <= bit_idx + 1'b1;
    end
  end

  // R1: the slot counter never runs past the frame end
  assert_idx_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= last_idx);

  // R8: a frame lasts either the nominal or the stretched length
  assert_len_choice_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> ((last_idx == CNT_W'(FRAME_W - 1)) || (last_idx == CNT_W'(FRAME_W))));
endmodule

// File: rtl/link_frame_tx.sv
module link_frame_tx import lft_pkg::*; #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              par_gen_i,
  input  logic              flag_i,
  output logic              rd_strobe_o,
  output logic              par_err_n_o,
  output logic              ser_o
);
  localparam int FRAME_W = DATA_W + OVH_W;

  logic               load_now;
  logic               take;
  logic               flag_now;
  logic               calc_par;
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] idle_frame;

  assign take        = load_now & valid_i & lock_i;
  assign rd_strobe_o = take;

  lft_flag_latch u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_in  (flag_i),
    .take     (take),
    .flag_now (flag_now)
  );

  lft_encoder #(.DATA_W(DATA_W)) u_enc (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_now),
    .use_data   (take),
    .flag       (flag_now),
    .data       (data_i),
    .frame      (frame),
    .idle_frame (idle_frame),
    .calc_par   (calc_par)
  );

  lft_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .stretch    (take & flag_now),
    .frame_in   (frame),
    .idle_frame (idle_frame),
    .load_now   (load_now),
    .ser_o      (ser_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        par_err_n_o <= 1'b1;
    else if (load_now) par_err_n_o <= !(take && !par_gen_i && (par_i != calc_par));
  end

  // R7: generate mode never reports an error
  assert_gen_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && par_gen_i) |=> par_err_n_o);

  // R4: a captured word always starts a data header on the line
  assert_strobe_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ser_o);

  // R10: a load while unlocked starts a stuffing frame with no error
  assert_unlocked_stuff_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_now && !lock_i) |=> (!ser_o && par_err_n_o));
endmodule

// File: tb/tb_link_frame_tx.sv
`timescale 1ns/1ps
module tb_link_frame_tx;
  localparam int DW = 36;
  localparam int FW = DW + 4;
  localparam int NV = 6;

  // {flag, par_gen, par_i, data}
  localparam logic [DW+2:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 36'hFFFFFFFFF},
    {1'b0, 1'b0, 1'b1, 36'hFFFFFFF00},
    {1'b1, 1'b1, 1'b1, 36'h000000001},
    {1'b0, 1'b0, 1'b0, 36'h000000000},
    {1'b0, 1'b0, 1'b1, 36'h123456789},
    {1'b1, 1'b1, 1'b0, 36'hAAAAAAAAA}
  };

  logic clk = 1'b0, rst_n = 1'b0, lock_i = 1'b0, valid_i = 1'b0;
  logic par_i = 1'b0, par_gen_i = 1'b0, flag_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  wire rd_strobe_o, par_err_n_o, ser_o;
  int n_run = 0, n_fail = 0, bdisp = 0;

  always #2.5 clk = ~clk;

  link_frame_tx #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .valid_i(valid_i), .data_i(data_i),
    .par_i(par_i), .par_gen_i(par_gen_i), .flag_i(flag_i),
    .rd_strobe_o(rd_strobe_o), .par_err_n_o(par_err_n_o), .ser_o(ser_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] stuffing();
    logic [DW-1:0] p;
    for (int i = 0; i < DW; i++) p[i] = (i % 2 == 1);
    return {2'b01, 1'b0, 1'b0, p};
  endfunction

  task automatic expect_frame(input logic [DW-1:0] d, input bit fl, output logic [FW-1:0] f);
    int ones = 0;
    int pd;
    bit inv;
    for (int i = 0; i < DW; i++) ones += d[i] ? 1 : 0;
    pd  = 2 * ones - DW;
    inv = (bdisp > 0 && pd > 0) || (bdisp < 0 && pd < 0);
    bdisp += inv ? -pd : pd;
    f = {(fl ? 2'b11 : 2'b10), inv, ^d, (inv ? ~d : d)};
  endtask

  task automatic collect(input int n, output logic [FW-1:0] f, output logic extra,
                         output int nstb, output int stb_at);
    f = '0; extra = 1'b1; nstb = 0; stb_at = -1;
    for (int j = 0; j < n; j++) begin
      if (j > 0) @(negedge clk);
      if (j == 1) flag_i = 1'b0;
      if (j < FW) f = {f[FW-2:0], ser_o};
      else extra = ser_o;
      if (rd_strobe_o) begin nstb++; stb_at = j; end
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [FW-1:0] f, ef;
    logic extra;
    int nstb, stb_at, len, cnt;
    bit exp_err;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(par_err_n_o == 1'b1, "R9 error output in reset", par_err_n_o, 1);
    check(rd_strobe_o == 1'b0, "R9 no strobe in reset", rd_strobe_o, 0);
    rst_n = 1'b1;
    collect(FW, f, extra, nstb, stb_at);
    check(f == stuffing(), "R9 R5 first frame is stuffing", f, stuffing());
    check(nstb == 0, "R4 no strobe with valid low", nstb, 0);

    // R10: unlocked with valid high
    @(negedge clk);
    valid_i = 1'b1; data_i = 36'h5A5A5A5A5;
    cnt = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (rd_strobe_o) cnt++;
    end
    check(cnt == 0, "R10 no strobe while unlocked", cnt, 0);
    valid_i = 1'b0; lock_i = 1'b1;

    // burst over the vector table
    @(negedge clk);
    {flag_i, par_gen_i, par_i, data_i} = VEC[0];
    valid_i = 1'b1;
    while (!rd_strobe_o) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      expect_frame(VEC[i][DW-1:0], VEC[i][DW+2], ef);
      exp_err = VEC[i][DW+1] ? 1'b0 : (VEC[i][DW] != ^VEC[i][DW-1:0]);
      len = FW + (VEC[i][DW+2] ? 1 : 0);
      @(posedge clk);
      @(negedge clk);
      check(par_err_n_o == !exp_err, "R7 parity error output", par_err_n_o, !exp_err);
      if (i < NV - 1) begin
        {flag_i, par_gen_i, par_i, data_i} = VEC[i+1];
      end else begin
        valid_i = 1'b0;
      end
      collect(len, f, extra, nstb, stb_at);
      check(f == ef, "R1 R2 R3 frame contents", f, ef);
      if (VEC[i][DW+2]) check(extra == 1'b0, "R8 extra zero slot", extra, 0);
      if (i < NV - 1)
        check(nstb == 1 && stb_at == len - 1, "R4 R8 strobe spacing", stb_at, len - 1);
      else
        check(nstb == 0, "R6 no strobe after last word", nstb, 0);
    end

    // R6: the frame after the last word is stuffing
    @(negedge clk);
    collect(FW, f, extra, nstb, stb_at);
    check(f == stuffing(), "R6 R5 stuffing after single word", f, stuffing());

    // R7 then R9: mismatching single word, then async reset mid-frame
    @(negedge clk);
    valid_i = 1'b1; par_gen_i = 1'b0; data_i = 36'h000000003; par_i = 1'b1;
    while (!rd_strobe_o) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    check(par_err_n_o == 1'b0, "R7 mismatch reported", par_err_n_o, 0);
    #1 rst_n = 1'b0;
    #0.5;
    check(par_err_n_o == 1'b1, "R9 async reset of error output", par_err_n_o, 1);
    check(ser_o == 1'b0, "R9 stuffing MSB after reset", ser_o, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule